// File: doc/BRIEF.md
# Thread Context Ring Matcher

This block takes a notification aimed at a virtual processor target and decides which privilege ring of one hardware thread context accepts it: user, OS, pool or physical. The target is given as a block number and an index, which together form a CAM line. The thread context supplies one 32-bit identity word per ring. The thread also supplies its processor id, and the controller supplies its block id and a thread-id-width setting.

For a regular notification (format 0), the rings are tried in a fixed priority order: physical, then pool, then OS. The physical ring is matched against a CAM line that the block builds from the processor id, not against a stored field. For a user-level notification (format 1), only the user ring can match, and only while the same thread also holds a matching OS context. Logical-server matching, requested with the ignore flag in format 0, is not implemented and is flagged as unsupported.

The result is registered, so it appears one clock after the inputs are sampled. The storage of the context words lives outside this block.

Top module: `ctx_ring_match`

## Requirements
- R1: While reset is asserted, `matchValid`, `matchRing` and `unsupported` are all 0.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge and stay unchanged between edges.
- R3: With `fmtUser`=0 and `camIgnore`=1, the block reports `unsupported`=1, `matchValid`=0 and `matchRing`=0, even when a ring would otherwise match.
- R4: With `fmtUser`=0, the physical ring is tried first. It matches (`matchRing`=3) when its valid bit is set and the target CAM line equals the thread's hardware CAM line. It wins over pool and OS matches.
- R5: The hardware CAM line is `{ctlBlk, idx}`. When `tid8Bit`=0, idx is 0x80 | procId[6:0]. When `tid8Bit`=1, idx is 0x100 | procId[7:0].
- R6: With `fmtUser`=0 and no physical match, the pool ring matches (`matchRing`=2) when its valid bit is set and its CAM field (logical bits [BLK_W+IDX_W-1:0]) equals `{tgtBlk, tgtIdx}`. It wins over an OS match.
- R7: With `fmtUser`=0 and neither physical nor pool matching, the OS ring matches (`matchRing`=1) under the same valid and CAM conditions applied to the OS word.
- R8: With `fmtUser`=1, only the user ring can match (`matchRing`=0). This requires all of the following: the OS valid bit is set, the OS CAM equals the target, the user valid bit is set, and the user logical-server field (logical bits [LS_W-1:0]) equals `logicServ`. Physical and pool matches have no effect.
- R9: Each context word arrives with its bytes reversed. Logical bit 31, the valid bit, sits at wire bit 7, and logical byte k sits in wire byte 3-k. A word whose logical layout is presented unswapped therefore does not match.
- R10: When no ring matches and the request is supported, `matchValid`=0, `matchRing`=0 and `unsupported`=0.
- R11: With `fmtUser`=1, `camIgnore` has no effect: a user match is still reported and `unsupported` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtUser | input | 1 | Notification format: 0 regular, 1 user level |
| tgtBlk | input | BLK_W | Target block |
| tgtIdx | input | IDX_W | Target index |
| camIgnore | input | 1 | Logical-server (ignore) request |
| logicServ | input | LS_W | Logical server number for the user ring |
| ctxUserW2 | input | 32 | User ring identity word, byte-reversed |
| ctxOsW2 | input | 32 | OS ring identity word, byte-reversed |
| ctxPoolW2 | input | 32 | Pool ring identity word, byte-reversed |
| ctxPhysW2 | input | 32 | Physical ring identity word, byte-reversed |
| procId | input | PIR_W | Processor id of the thread |
| ctlBlk | input | BLK_W | Controller block id |
| tid8Bit | input | 1 | Thread id width select: 0 selects 7 bits, 1 selects 8 bits |
| matchValid | output | 1 | A ring matched |
| matchRing | output | 2 | Matched ring: 0 user, 1 OS, 2 pool, 3 physical |
| unsupported | output | 1 | Logical-server request not supported |

## Verification
The assertions check the following on every cycle:
- The unsupported flag never coexists with a match.
- An idle ring output is zero.
- A user-ring result only follows a format-1 request.
- A physical hit in format 0 always wins.
- The datapath never reports a user hit without an OS hit.

Other behaviours can only be shown by the bench's scenarios:
- The exact hardware CAM line in each thread-id width.
- The pool-over-OS ordering.
- The byte reversal of the context words.
- The one-cycle latency.
- The logical-server gating of the user ring.

// File: rtl/ctx_ring_match_pkg.sv
package ctx_ring_match_pkg;

  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;

  // Raw per-ring compare results handed from datapath to control.
  typedef struct packed {
    logic phys;
    logic pool;
    logic os;
    logic user;
  } ring_hits_t;

  function automatic logic [31:0] byteSwap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/ctx_ring_match_dp.sv
module ctx_ring_match_dp
  import ctx_ring_match_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int IDX_W = 20,
  parameter int LS_W  = 12,
  parameter int PIR_W = 16
) (
  input  logic [BLK_W-1:0] tgtBlk,
  input  logic [IDX_W-1:0] tgtIdx,
  input  logic [LS_W-1:0]  logicServ,
  input  logic [31:0]      ctxUserW2,
  input  logic [31:0]      ctxOsW2,
  input  logic [31:0]      ctxPoolW2,
  input  logic [31:0]      ctxPhysW2,
  input  logic [PIR_W-1:0] procId,
  input  logic [BLK_W-1:0] ctlBlk,
  input  logic             tid8Bit,
  output ring_hits_t       hits
);

  localparam int CAM_W     = BLK_W + IDX_W;
  localparam int VALID_BIT = 31;
  localparam int N_CAM_RINGS = 2;  // pool and OS carry a stored CAM field

  // Words converted from wire byte order to logical order.
  logic [31:0] userWord, osWord, poolWord, physWord;
  assign userWord = byteSwap32(ctxUserW2);
  assign osWord   = byteSwap32(ctxOsW2);
  assign poolWord = byteSwap32(ctxPoolW2);
  assign physWord = byteSwap32(ctxPhysW2);

  logic [CAM_W-1:0] tgtCam;
  assign tgtCam = {tgtBlk, tgtIdx};

  // Hardware CAM line built from the processor id.
  logic [IDX_W-1:0] hwIdx;
  always_comb begin
    hwIdx = '0;
    if (tid8Bit) begin
      hwIdx[8]   = 1'b1;
      hwIdx[7:0] = procId[7:0];
    end else begin
      hwIdx[7]   = 1'b1;
      hwIdx[6:0] = procId[6:0];
    end
  end

  logic [CAM_W-1:0] hwCam;
  assign hwCam = {ctlBlk, hwIdx};

  // Stored-CAM rings compared in a uniform way.
  logic [N_CAM_RINGS-1:0][31:0] camWords;
  logic [N_CAM_RINGS-1:0]       camHit;
  assign camWords[0] = poolWord;
  assign camWords[1] = osWord;

  for (genvar g = 0; g < N_CAM_RINGS; g++) begin : gCamRing
    assign camHit[g] = camWords[g][VALID_BIT] &&
                       (camWords[g][CAM_W-1:0] == tgtCam);
  end

  logic lsEq;
  assign lsEq = (userWord[LS_W-1:0] == logicServ);

  assign hits.phys = physWord[VALID_BIT] && (hwCam == tgtCam);
  assign hits.pool = camHit[0];
  assign hits.os   = camHit[1];
  assign hits.user = camHit[1] && userWord[VALID_BIT] && lsEq;

endmodule

// File: rtl/ctx_ring_match_ctl.sv
module ctx_ring_match_ctl
  import ctx_ring_match_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fmtUser,
  input  logic       camIgnore,
  input  ring_hits_t hits,
  output logic       matchValid,
  output logic [1:0] matchRing,
  output logic       unsupported
);

  logic  nextValid;
  ring_e nextRing;
  logic  nextUnsup;

  always_comb begin
    nextValid = 1'b0;
    nextRing  = RING_USER;
    nextUnsup = 1'b0;
    if (!fmtUser) begin
      if (camIgnore) begin
        nextUnsup = 1'b1;
      end else if (hits.phys) begin
        nextValid = 1'b1;
        nextRing  = RING_PHYS;
      end else if (hits.pool) begin
        nextValid = 1'b1;
        nextRing  = RING_POOL;
      end else if (hits.os) begin
        nextValid = 1'b1;
        nextRing  = RING_OS;
      end
    end else if (hits.user) begin
      nextValid = 1'b1;
      nextRing  = RING_USER;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchValid  <= 1'b0;
      matchRing   <= 2'd0;
      unsupported <= 1'b0;
    end else begin
      matchValid  <= nextValid;
      matchRing   <= nextRing;
      unsupported <= nextUnsup;
    end
  end

  // R3: an unsupported request never reports a ring
  a_r3_unsup_no_match: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> (!matchValid && matchRing == 2'd0));

  // R10: idle result carries ring zero
  a_r10_idle_ring_zero: assert property (@(posedge clk) disable iff (!rstN)
    !matchValid |-> matchRing == 2'd0);

  // R8: a user-ring result only follows a format-1 request
  a_r8_user_from_fmt1: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && matchRing == 2'd0) |-> $past(fmtUser));

  // R4: a physical hit in format 0 always wins on the next cycle
  a_r4_phys_wins: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(hits.phys && !fmtUser && !camIgnore))
      |-> (matchValid && matchRing == 2'd3));

  // R8: the datapath cannot see a user hit without an OS hit
  a_r8_user_needs_os: assert property (@(posedge clk) disable iff (!rstN)
    hits.user |-> hits.os);

endmodule

// File: rtl/ctx_ring_match.sv
module ctx_ring_match
  import ctx_ring_match_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int IDX_W = 20,
  parameter int LS_W  = 12,
  parameter int PIR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fmtUser,
  input  logic [BLK_W-1:0] tgtBlk,
  input  logic [IDX_W-1:0] tgtIdx,
  input  logic             camIgnore,
  input  logic [LS_W-1:0]  logicServ,
  input  logic [31:0]      ctxUserW2,
  input  logic [31:0]      ctxOsW2,
  input  logic [31:0]      ctxPoolW2,
  input  logic [31:0]      ctxPhysW2,
  input  logic [PIR_W-1:0] procId,
  input  logic [BLK_W-1:0] ctlBlk,
  input  logic             tid8Bit,
  output logic             matchValid,
  output logic [1:0]       matchRing,
  output logic             unsupported
);

  ring_hits_t hits;

  ctx_ring_match_dp #(
    .BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W), .PIR_W(PIR_W)
  ) uDp (
    .tgtBlk(tgtBlk), .tgtIdx(tgtIdx), .logicServ(logicServ),
    .ctxUserW2(ctxUserW2), .ctxOsW2(ctxOsW2),
    .ctxPoolW2(ctxPoolW2), .ctxPhysW2(ctxPhysW2),
    .procId(procId), .ctlBlk(ctlBlk), .tid8Bit(tid8Bit),
    .hits(hits)
  );

  ctx_ring_match_ctl uCtl (
    .clk(clk), .rstN(rstN), .fmtUser(fmtUser), .camIgnore(camIgnore),
    .hits(hits), .matchValid(matchValid), .matchRing(matchRing),
    .unsupported(unsupported)
  );

endmodule

// File: tb/ctx_ring_match_test.sv
module ctx_ring_match_test;

  localparam int BLK_W = 4;
  localparam int IDX_W = 20;
  localparam int LS_W  = 12;
  localparam int PIR_W = 16;
  localparam int CAM_W = BLK_W + IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fmtUser = 1'b0, camIgnore = 1'b0, tid8Bit = 1'b0;
  logic [BLK_W-1:0] tgtBlk = '0, ctlBlk = '0;
  logic [IDX_W-1:0] tgtIdx = '0;
  logic [LS_W-1:0]  logicServ = '0;
  logic [31:0] ctxUserW2 = '0, ctxOsW2 = '0, ctxPoolW2 = '0, ctxPhysW2 = '0;
  logic [PIR_W-1:0] procId = '0;
  logic matchValid, unsupported;
  logic [1:0] matchRing;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  ctx_ring_match #(.BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W), .PIR_W(PIR_W)) uut (
    .clk(clk), .rstN(rstN), .fmtUser(fmtUser), .tgtBlk(tgtBlk), .tgtIdx(tgtIdx),
    .camIgnore(camIgnore), .logicServ(logicServ),
    .ctxUserW2(ctxUserW2), .ctxOsW2(ctxOsW2), .ctxPoolW2(ctxPoolW2),
    .ctxPhysW2(ctxPhysW2), .procId(procId), .ctlBlk(ctlBlk), .tid8Bit(tid8Bit),
    .matchValid(matchValid), .matchRing(matchRing), .unsupported(unsupported)
  );

  function automatic logic [31:0] wire32(input logic [31:0] l);
    return {l[7:0], l[15:8], l[23:16], l[31:24]};
  endfunction

  function automatic logic [31:0] camWord(input logic v, input logic [CAM_W-1:0] cam);
    logic [31:0] l;
    l = '0;
    l[31] = v;
    l[CAM_W-1:0] = cam;
    return wire32(l);
  endfunction

  function automatic logic [31:0] lsWord(input logic v, input logic [LS_W-1:0] ls);
    logic [31:0] l;
    l = '0;
    l[31] = v;
    l[LS_W-1:0] = ls;
    return wire32(l);
  endfunction

  task automatic check(input string req, input logic expV, input logic [1:0] expR,
                       input logic expU);
    compared++;
    if (matchValid !== expV || matchRing !== expR || unsupported !== expU) begin
      mismatched++;
      $display("FAIL %s: actual v=%b ring=%0d unsup=%b expected v=%b ring=%0d unsup=%b",
               req, matchValid, matchRing, unsupported, expV, expR, expU);
    end
  endtask

  // Apply current inputs: they are sampled at the next edge; check after it.
  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic clearRings;
    @(negedge clk);
    fmtUser = 0; camIgnore = 0;
    ctxUserW2 = '0; ctxOsW2 = '0; ctxPoolW2 = '0; ctxPhysW2 = '0;
  endtask

  task automatic testReset;
    #1;
    check("R1 reset", 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset held", 0, 0, 0);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic testPhys;
    clearRings();
    ctlBlk = 4'h5; procId = 16'h1234; tid8Bit = 0;
    tgtBlk = 4'h5; tgtIdx = 20'h000B4;
    ctxPhysW2 = camWord(1, '0);
    ctxPoolW2 = camWord(1, {4'h5, 20'h000B4});
    ctxOsW2   = camWord(1, {4'h5, 20'h000B4});
    step();
    check("R4 phys wins over pool/os", 1, 3, 0);
    check("R5 7-bit hw cam", matchValid, 3, 0);
    @(negedge clk);
    tid8Bit = 1;
    ctxPoolW2 = '0; ctxOsW2 = '0;
    step();
    check("R5 7-bit target rejected in 8-bit mode", 0, 0, 0);
    @(negedge clk);
    tgtIdx = 20'h00134;
    step();
    check("R5 8-bit hw cam", 1, 3, 0);
    @(negedge clk);
    ctlBlk = 4'h6;
    step();
    check("R5 controller block part of hw cam", 0, 0, 0);
  endtask

  task automatic testPoolOs;
    clearRings();
    tgtBlk = 4'h2; tgtIdx = 20'hABCDE;
    ctxPhysW2 = camWord(1, '0);
    ctxPoolW2 = camWord(1, {4'h2, 20'hABCDE});
    ctxOsW2   = camWord(1, {4'h2, 20'hABCDE});
    step();
    check("R6 pool wins over os", 1, 2, 0);
    @(negedge clk);
    ctxPoolW2 = camWord(1, {4'h2, 20'hABCDF});
    step();
    check("R7 os when pool cam differs", 1, 1, 0);
    @(negedge clk);
    ctxPoolW2 = camWord(0, {4'h2, 20'hABCDE});
    ctxOsW2   = camWord(0, {4'h2, 20'hABCDE});
    step();
    check("R10 valid bits clear, no match", 0, 0, 0);
  endtask

  task automatic testIgnore;
    clearRings();
    ctlBlk = 4'h5; procId = 16'h1234; tid8Bit = 0;
    tgtBlk = 4'h5; tgtIdx = 20'h000B4;
    ctxPhysW2 = camWord(1, '0);
    camIgnore = 1;
    step();
    check("R3 ignore flag unsupported", 0, 0, 1);
  endtask

  task automatic testUser;
    clearRings();
    fmtUser = 1;
    tgtBlk = 4'h9; tgtIdx = 20'h01234;
    logicServ = 12'h3A5;
    ctxOsW2   = camWord(1, {4'h9, 20'h01234});
    ctxUserW2 = lsWord(1, 12'h3A5);
    ctxPoolW2 = camWord(1, {4'h9, 20'h01234});
    step();
    check("R8 user ring match", 1, 0, 0);
    @(negedge clk);
    camIgnore = 1;
    step();
    check("R11 ignore flag no effect in format 1", 1, 0, 0);
    @(negedge clk);
    camIgnore = 0;
    logicServ = 12'h3A4;
    step();
    check("R8 logical server mismatch", 0, 0, 0);
    @(negedge clk);
    logicServ = 12'h3A5;
    ctxOsW2 = camWord(0, {4'h9, 20'h01234});
    step();
    check("R8 OS context required", 0, 0, 0);
    @(negedge clk);
    ctxOsW2 = camWord(1, {4'h9, 20'h01234});
    ctxUserW2 = lsWord(0, 12'h3A5);
    step();
    check("R8 user valid required, pool ignored", 0, 0, 0);
  endtask

  task automatic testByteOrderLatency;
    logic [31:0] l;
    clearRings();
    tgtBlk = 4'h3; tgtIdx = 20'h55555;
    l = '0; l[31] = 1'b1; l[CAM_W-1:0] = {4'h3, 20'h55555};
    ctxOsW2 = l;
    step();
    check("R9 unswapped word rejected", 0, 0, 0);
    @(negedge clk);
    ctxOsW2 = wire32(l);
    step();
    check("R9 swapped word matches", 1, 1, 0);
    @(negedge clk);
    ctxOsW2 = '0;
    #2;
    check("R2 output holds until edge", 1, 1, 0);
    step();
    check("R2 output updates after edge", 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testPhys();
        testPoolOs();
        testIgnore();
        testUser();
        testByteOrderLatency();
      end
      begin
        repeat (5000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule